// File: doc/BRIEF.md
# Dual-Mode Four-Channel Host Bus Front End

This block sits between a host processor bus and four peripheral channels. Each channel has eight byte-wide registers. A static mode input picks one of two bus conventions. In strobe mode (mode input 1) the host uses separate active-low read and write strobes and one active-low select per channel. In level mode (mode input 0) the host uses one device select and a read/write level, and two of the former select pins carry the channel number. The block samples the pins on its clock, decodes the access, and issues one-cycle register read and write strobes to the addressed channel with a 3-bit register address. During a read it drives the returned byte onto the data bus.

Each channel is modelled here as a simple eight-entry register file. Register 4 of each channel is that channel's control register, and its bit 3 enables the channel's interrupt driver. The interrupt outputs take the form the mode needs. Strobe mode has one enabled driver per channel. Level mode has one shared active-low open-drain request, given as a pull-low enable.

The control state machine has five states. ST_IDLE waits for a decoded access. ST_RD_START issues the read strobe and captures the data. ST_RD_HOLD drives the data bus while the read stays active. ST_WR_HOLD tracks the bus data while the write stays active. ST_WR_COMMIT issues the write strobe. The transitions are:
- ST_IDLE to ST_RD_START on a read request.
- ST_IDLE to ST_WR_HOLD on a write request. Read requests win, although the decoder never raises both.
- ST_RD_START to ST_RD_HOLD always.
- ST_RD_HOLD to ST_IDLE once the read request ends or its channel changes.
- ST_WR_HOLD to ST_WR_COMMIT once the write request ends or its channel changes.
- ST_WR_COMMIT to ST_IDLE always.

Top module: `hbq_front`

## Requirements
- R1: After reset, dout_oe, irq_oe, irq_val and irq_pull_low are all 0. No register strobe fires, and every register reads back 0.
- R2: In strobe mode (mode_sel=1), with exactly one select cs_n[i] low (bit i = channel i), a low pulse on wr_n writes the din value present just before wr_n rises into register addr of channel i. reg_wr pulses for one cycle with only bit i set, carrying reg_addr and reg_wdata.
- R3: In strobe mode, while rd_n is low with exactly one select cs_n[i] low, dout_oe goes to 1 and dout holds register addr of channel i. dout_oe returns to 0 after rd_n rises.
- R4: In strobe mode, an access with two or more selects low is ignored: no strobe fires, dout_oe stays 0, and no register changes.
- R5: In level mode (mode_sel=0), cs_n[0] is the active-low device select and wr_n is the read/write level (1 = read, 0 = write). The channel number is {cs_n[2], cs_n[1]}: 00 = channel 0, 01 = channel 1, 10 = channel 2, 11 = channel 3. A write commits after cs_n[0] rises.
- R6: In level mode, rd_n and cs_n[3] have no effect on any access.
- R7: In strobe mode, a strobe with no select low, or with rd_n and wr_n low together, is ignored.
- R8: In strobe mode, irq_oe[i] equals bit 3 of channel i's register 4, and irq_val[i] is 1 only when irq_req[i] is 1 and irq_oe[i] is 1.
- R9: In level mode, irq_oe and irq_val are 0, and irq_pull_low is 1 exactly when any irq_req bit is 1.
- R10: dout_oe is 1 only while a read is held. It stays 0 throughout a write.
- R11: Each read issues exactly one one-cycle reg_rd pulse with only the channel's bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | 1 = strobe mode, 0 = level mode (static) |
| rd_n | input | 1 | Read strobe, active low (strobe mode only) |
| wr_n | input | 1 | Write strobe (strobe mode) or read/write level (level mode) |
| cs_n | input | 4 | Per-channel selects, or device select plus channel bits |
| addr | input | 3 | Register address within a channel |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | Data bus drive enable |
| reg_rd | output | 4 | One-hot per-channel register read strobe |
| reg_wr | output | 4 | One-hot per-channel register write strobe |
| reg_addr | output | 3 | Register address for the strobes |
| reg_wdata | output | 8 | Write data for reg_wr |
| irq_req | input | 4 | Pending interrupt per channel |
| irq_val | output | 4 | Per-channel interrupt level (strobe mode) |
| irq_oe | output | 4 | Per-channel interrupt drive enable (strobe mode) |
| irq_pull_low | output | 1 | Shared open-drain pull-low enable (level mode) |

## Verification
A write that commits a new control-register value can land in the same cycle as a change on irq_req for that channel.

The bench raises irq_req[1] at the same clock edge where wr_n rises on a write that sets the interrupt enable bit in channel 1's control register. It then checks two things:
- irq_val[1] stays 0 while the commit is still in flight.
- irq_oe[1] and irq_val[1] both go to 1 once the commit has landed.

A read held on one channel while its interrupt changes is also checked: the returned data must stay intact.

// File: rtl/hbq_pkg.sv
package hbq_pkg;
    localparam int NCH      = 4;
    localparam int CHW      = $clog2(NCH);
    localparam int AW       = 3;
    localparam int DW       = 8;
    localparam int NREG     = 1 << AW;
    localparam int CTL_REG  = 4;
    localparam int IRQ_EN_BIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_HOLD,
        ST_WR_HOLD,
        ST_WR_COMMIT
    } hbq_state_e;
endpackage

// File: rtl/hbq_decode.sv
module hbq_decode
    import hbq_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int CH_W = CHW
) (
    input  logic            mode_sel,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [N_CH-1:0] cs_n,
    output logic            rd_req,
    output logic            wr_req,
    output logic [CH_W-1:0] ch
);
    logic [N_CH-1:0] sel_lo;
    logic            sel_ok;

    always_comb begin
        sel_lo = ~cs_n;
        ch     = '0;
        if (mode_sel) begin
            sel_ok = $onehot(sel_lo);
            for (int i = 0; i < N_CH; i++)
                if (sel_lo[i]) ch = i[CH_W-1:0];
            rd_req = sel_ok && !rd_n && wr_n;
            wr_req = sel_ok && !wr_n && rd_n;
        end else begin
            sel_ok = !cs_n[0];
            ch     = cs_n[CH_W:1];
            rd_req = sel_ok && wr_n;
            wr_req = sel_ok && !wr_n;
        end
    end

    // R7: a decoded access is never both a read and a write
    always_comb begin
        a_r7_one_kind: assert (!(rd_req && wr_req));
    end
endmodule

// File: rtl/hbq_regfile.sv
module hbq_regfile
    import hbq_pkg::*;
#(
    parameter int N_CH   = NCH,
    parameter int CH_W   = CHW,
    parameter int A_W    = AW,
    parameter int D_W    = DW,
    parameter int N_REG  = NREG,
    parameter int CTL_IX = CTL_REG,
    parameter int EN_BIT = IRQ_EN_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] wr_en,
    input  logic [A_W-1:0]  wr_addr,
    input  logic [D_W-1:0]  wr_data,
    input  logic [CH_W-1:0] rd_ch,
    input  logic [A_W-1:0]  rd_addr,
    output logic [D_W-1:0]  rd_data,
    output logic [N_CH-1:0] irq_en
);
    logic [D_W-1:0] ch_rd [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [D_W-1:0] mem [N_REG];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < N_REG; r++) mem[r] <= '0;
            end else if (wr_en[c]) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign ch_rd[c]  = mem[rd_addr];
        assign irq_en[c] = mem[CTL_IX][EN_BIT];

        // R2: a strobed write lands in the addressed register
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[c] |=> mem[$past(wr_addr)] == $past(wr_data));
    end

    assign rd_data = ch_rd[rd_ch];
endmodule

// File: rtl/hbq_ctrl.sv
module hbq_ctrl
    import hbq_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int CH_W = CHW,
    parameter int A_W  = AW,
    parameter int D_W  = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_req,
    input  logic [CH_W-1:0] dch,
    input  logic [A_W-1:0]  s_addr,
    input  logic [D_W-1:0]  s_din,
    input  logic [D_W-1:0]  rf_rdata,
    output logic [CH_W-1:0] ch_q,
    output logic [A_W-1:0]  addr_q,
    output logic [D_W-1:0]  data_q,
    output logic [N_CH-1:0] reg_rd,
    output logic [N_CH-1:0] reg_wr,
    output logic [D_W-1:0]  dout,
    output logic            dout_oe
);
    hbq_state_e    state, nx;
    logic [D_W-1:0] rdata_q;
    logic          rd_held, wr_held;

    assign rd_held = rd_req && (dch == ch_q);
    assign wr_held = wr_req && (dch == ch_q);

    always_comb begin
        nx = state;
        unique case (state)
            ST_IDLE:      if (rd_req) nx = ST_RD_START;
                          else if (wr_req) nx = ST_WR_HOLD;
            ST_RD_START:  nx = ST_RD_HOLD;
            ST_RD_HOLD:   if (!rd_held) nx = ST_IDLE;
            ST_WR_HOLD:   if (!wr_held) nx = ST_WR_COMMIT;
            ST_WR_COMMIT: nx = ST_IDLE;
            default:      nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ch_q    <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            state <= nx;
            if ((state == ST_IDLE && (rd_req || wr_req)) ||
                (state == ST_WR_HOLD && wr_held)) begin
                if (state == ST_IDLE) ch_q <= dch;
                addr_q <= s_addr;
                data_q <= s_din;
            end
            if (state == ST_RD_START) rdata_q <= rf_rdata;
        end
    end

    always_comb begin
        reg_rd  = (state == ST_RD_START)  ? (N_CH'(1) << ch_q) : '0;
        reg_wr  = (state == ST_WR_COMMIT) ? (N_CH'(1) << ch_q) : '0;
        dout_oe = (state == ST_RD_HOLD);
        dout    = dout_oe ? rdata_q : '0;
    end

    // R11: a read strobe lasts exactly one cycle
    a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_rd) |=> reg_rd == '0);
    // R10: the data bus is released the cycle after the read request ends
    a_r10_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !rd_req) |=> !dout_oe);
    // R2: a commit is followed by no second commit and no bus drive
    a_r2_commit_once: assert property (@(posedge clk) disable iff (!rst_n)
        (|reg_wr) |=> (reg_wr == '0) && !dout_oe);
endmodule

// File: rtl/hbq_irq.sv
module hbq_irq
    import hbq_pkg::*;
#(
    parameter int N_CH = NCH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_sel,
    input  logic [N_CH-1:0] irq_req,
    input  logic [N_CH-1:0] irq_en,
    output logic [N_CH-1:0] irq_val,
    output logic [N_CH-1:0] irq_oe,
    output logic            irq_pull_low
);
    always_comb begin
        irq_oe       = mode_sel ? irq_en : '0;
        irq_val      = irq_oe & irq_req;
        irq_pull_low = !mode_sel && (|irq_req);
    end

    // R8: per-channel drivers exist only in strobe mode
    a_r8_oe_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_oe) |-> mode_sel);
    // R9: the shared request pulls low only for a pending level-mode interrupt
    a_r9_pull_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_low |-> (!mode_sel && (irq_req != '0) && (irq_val == '0)));
endmodule

// File: rtl/hbq_front.sv
module hbq_front
    import hbq_pkg::*;
#(
    parameter int N_CH = NCH,
    parameter int A_W  = AW,
    parameter int D_W  = DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_sel,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [N_CH-1:0] cs_n,
    input  logic [A_W-1:0]  addr,
    input  logic [D_W-1:0]  din,
    output logic [D_W-1:0]  dout,
    output logic            dout_oe,
    output logic [N_CH-1:0] reg_rd,
    output logic [N_CH-1:0] reg_wr,
    output logic [A_W-1:0]  reg_addr,
    output logic [D_W-1:0]  reg_wdata,
    input  logic [N_CH-1:0] irq_req,
    output logic [N_CH-1:0] irq_val,
    output logic [N_CH-1:0] irq_oe,
    output logic            irq_pull_low
);
    localparam int CH_W = $clog2(N_CH);

    logic            s_rd_n, s_wr_n;
    logic [N_CH-1:0] s_cs_n;
    logic [A_W-1:0]  s_addr;
    logic [D_W-1:0]  s_din;
    logic            rd_req, wr_req;
    logic [CH_W-1:0] dch, ch_q;
    logic [D_W-1:0]  rf_rdata;
    logic [N_CH-1:0] irq_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_rd_n <= 1'b1;
            s_wr_n <= 1'b1;
            s_cs_n <= '1;
            s_addr <= '0;
            s_din  <= '0;
        end else begin
            s_rd_n <= rd_n;
            s_wr_n <= wr_n;
            s_cs_n <= cs_n;
            s_addr <= addr;
            s_din  <= din;
        end
    end

    hbq_decode #(.N_CH(N_CH), .CH_W(CH_W)) u_dec (
        .mode_sel(mode_sel), .rd_n(s_rd_n), .wr_n(s_wr_n), .cs_n(s_cs_n),
        .rd_req(rd_req), .wr_req(wr_req), .ch(dch));

    hbq_ctrl #(.N_CH(N_CH), .CH_W(CH_W), .A_W(A_W), .D_W(D_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .dch(dch), .s_addr(s_addr), .s_din(s_din), .rf_rdata(rf_rdata),
        .ch_q(ch_q), .addr_q(reg_addr), .data_q(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .dout(dout), .dout_oe(dout_oe));

    hbq_regfile #(.N_CH(N_CH), .CH_W(CH_W), .A_W(A_W), .D_W(D_W),
                  .N_REG(1 << A_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .rd_ch(ch_q), .rd_addr(reg_addr),
        .rd_data(rf_rdata), .irq_en(irq_en));

    hbq_irq #(.N_CH(N_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .irq_req(irq_req),
        .irq_en(irq_en), .irq_val(irq_val), .irq_oe(irq_oe),
        .irq_pull_low(irq_pull_low));
endmodule

// File: tb/tb_hbq_front.sv
module tb_hbq_front;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       mode_sel = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] cs_n = 4'hF;
    logic [2:0] addr = '0;
    logic [7:0] din = '0;
    logic [3:0] irq_req = '0;
    logic [7:0] dout, reg_wdata;
    logic       dout_oe, irq_pull_low;
    logic [3:0] reg_rd, reg_wr, irq_val, irq_oe;
    logic [2:0] reg_addr;

    int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
    logic [3:0] last_wr_mask, last_rd_mask;
    logic [2:0] last_wa;
    logic [7:0] last_wd;
    logic [7:0] model [4][8];

    always #10 clk = ~clk;

    hbq_front dut (.*);

    always @(negedge clk) begin
        if (|reg_wr) begin
            wr_cnt++; last_wr_mask = reg_wr; last_wa = reg_addr; last_wd = reg_wdata;
        end
        if (|reg_rd) begin
            rd_cnt++; last_rd_mask = reg_rd;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic s_write(input int c, input logic [2:0] a, input logic [7:0] d);
        int w0 = wr_cnt;
        addr = a; din = 8'h00; cs_n = ~(4'b1 << c); cyc(1);
        wr_n = 1'b0; cyc(2);
        check("R10 no drive during write", dout_oe, 0);
        din = d; cyc(2);
        wr_n = 1'b1; cyc(1); din = 8'h5A; cs_n = 4'hF; cyc(4);
        model[c][a] = d;
        check("R2 single commit", wr_cnt - w0, 1);
        check("R2 commit channel", last_wr_mask, 4'b1 << c);
        check("R2 commit addr/data", {last_wa, last_wd}, {a, d});
    endtask

    task automatic s_read(input int c, input logic [2:0] a, input string tag);
        int r0 = rd_cnt;
        addr = a; cs_n = ~(4'b1 << c); cyc(1);
        rd_n = 1'b0; cyc(4);
        check({tag, " oe during read"}, dout_oe, 1);
        check({tag, " data"}, dout, model[c][a]);
        rd_n = 1'b1; cyc(1); cs_n = 4'hF; cyc(4);
        check("R3 oe released", dout_oe, 0);
        check("R11 one read strobe", rd_cnt - r0, 1);
        check("R11 read strobe channel", last_rd_mask, 4'b1 << c);
    endtask

    task automatic l_write(input int c, input logic [2:0] a, input logic [7:0] d, input logic c3);
        addr = a; din = d; wr_n = 1'b0;
        cs_n = {c3, c[1], c[0], 1'b1}; cyc(1);
        cs_n[0] = 1'b0; cyc(3);
        cs_n[0] = 1'b1; cyc(5);
        model[c][a] = d;
    endtask

    task automatic l_read(input int c, input logic [2:0] a, input logic c3, input string tag);
        addr = a; wr_n = 1'b1;
        cs_n = {c3, c[1], c[0], 1'b1}; cyc(1);
        cs_n[0] = 1'b0; cyc(4);
        check({tag, " oe"}, dout_oe, 1);
        check({tag, " data"}, dout, model[c][a]);
        cs_n[0] = 1'b1; cyc(4);
        check("R10 level read released", dout_oe, 0);
    endtask

    task automatic t_reset;
        check("R1 dout_oe", dout_oe, 0);
        check("R1 irq outputs", {irq_oe, irq_val, irq_pull_low}, 0);
        check("R1 no strobes", wr_cnt + rd_cnt, 0);
        s_read(3, 3'd7, "R1 reset value");
    endtask

    task automatic t_strobe_rw;
        s_write(0, 3'd1, 8'h11);
        s_write(1, 3'd1, 8'h22);
        s_write(2, 3'd6, 8'hC3);
        s_write(3, 3'd0, 8'h9F);
        for (int c = 0; c < 4; c++) s_read(c, (c == 2) ? 3'd6 : (c == 3) ? 3'd0 : 3'd1, "R3 read");
    endtask

    task automatic t_strobe_ignored;
        int w0 = wr_cnt, r0 = rd_cnt;
        addr = 3'd1; din = 8'hEE; cs_n = 4'b1100; cyc(1);
        wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(1);
        rd_n = 1'b0; cyc(3);
        check("R4 two selects no read drive", dout_oe, 0);
        rd_n = 1'b1; cs_n = 4'hF; cyc(1);
        wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(1);
        cs_n = 4'b0111; rd_n = 1'b0; wr_n = 1'b0; cyc(4);
        check("R7 both strobes no drive", dout_oe, 0);
        rd_n = 1'b1; wr_n = 1'b1; cs_n = 4'hF; cyc(4);
        check("R4 R7 no strobes", {wr_cnt - w0, rd_cnt - r0}, 0);
        s_read(0, 3'd1, "R4 channel 0 kept");
        s_read(1, 3'd1, "R4 channel 1 kept");
    endtask

    task automatic t_strobe_irq;
        irq_req = 4'b1111; cyc(1);
        check("R8 no enable no drive", {irq_oe, irq_val}, 0);
        s_write(2, 3'd4, 8'h08);
        check("R8 enable ch2", irq_oe, 4'b0100);
        check("R8 level ch2", irq_val, 4'b0100);
        irq_req = 4'b0000; cyc(1);
        check("R8 not pending", {irq_oe, irq_val}, {4'b0100, 4'b0000});
        // same-cycle case: interrupt rises on the edge that ends an enable write
        addr = 3'd4; cs_n = 4'b1101; cyc(1);
        wr_n = 1'b0; din = 8'h08; cyc(3);
        wr_n = 1'b1; irq_req = 4'b0010; cyc(1);
        check("R8 before commit", irq_val[1], 0);
        cs_n = 4'hF; cyc(4);
        model[1][4] = 8'h08;
        check("R8 after commit oe", irq_oe, 4'b0110);
        check("R8 after commit val", irq_val, 4'b0010);
        s_write(2, 3'd4, 8'h00);
        check("R8 enable cleared", irq_oe, 4'b0010);
        irq_req = 4'b0000;
    endtask

    task automatic t_level;
        int r0;
        mode_sel = 1'b0; rd_n = 1'b0; wr_n = 1'b1; cs_n = 4'hF; cyc(2);
        r0 = rd_cnt;
        cyc(3);
        check("R6 rd_n alone no access", {dout_oe, rd_cnt - r0}, 0);
        l_write(0, 3'd2, 8'hA0, 1'b1);
        l_write(1, 3'd2, 8'hB1, 1'b0);
        l_write(2, 3'd2, 8'hC2, 1'b1);
        l_write(3, 3'd2, 8'hD3, 1'b0);
        check("R5 commit to channel 3", {last_wr_mask, last_wd}, {4'b1000, 8'hD3});
        l_read(0, 3'd2, 1'b0, "R5 ch0");
        l_read(1, 3'd2, 1'b1, "R5 ch1");
        l_read(2, 3'd2, 1'b0, "R6 ch2 cs3 low");
        rd_n = 1'b1;
        l_read(3, 3'd2, 1'b1, "R6 ch3 rd_n high");
        l_read(1, 3'd1, 1'b0, "R5 earlier value");
    endtask

    task automatic t_level_irq;
        check("R9 no pending", {irq_oe, irq_val, irq_pull_low}, 0);
        irq_req = 4'b0010; cyc(1);
        check("R9 pending ch1 pull", irq_pull_low, 1);
        check("R9 no per-channel drive", {irq_oe, irq_val}, 0);
        irq_req = 4'b1000; cyc(1);
        check("R9 pending ch3 pull", irq_pull_low, 1);
        irq_req = 4'b0000; cyc(1);
        check("R9 released", irq_pull_low, 0);
    endtask

    initial begin
        for (int c = 0; c < 4; c++) for (int a = 0; a < 8; a++) model[c][a] = 8'h00;
        cyc(3); rst_n = 1'b1; cyc(2);
        t_reset;
        t_strobe_rw;
        t_strobe_ignored;
        t_strobe_irq;
        t_level;
        t_level_irq;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule